// File: doc/BRIEF.md
# Dual-Speed FSK Cassette Tone Modulator

This block turns a serial bit stream into a logic-level square-wave tone for recording on audio tape, using frequency-shift keying. A base tick is derived from the system clock by a programmable divisor. In low-speed mode every base tick is a tone tick. In high-speed mode every second base tick is a tone tick. The tone tick drives a two-stage toggle divider. When the current bit is one, the output toggles on every tone tick. When the bit is zero, a first toggle stage gates the output stage, so the output runs at a quarter of the tone tick rate.

A serializer asserts a one-cycle bit-boundary strobe at the start of each bit. The block captures the serial data and the speed select only in that cycle. Between strobes, changes on those inputs cannot alter the tone. The nominal bit period is 16 tone ticks in low-speed mode and 2 tone ticks in high-speed mode. With a base tick equivalent to 4800 Hz, this gives 300 bit/s with tones of 1200 Hz and 2400 Hz, or 1200 bit/s with tones of 600 Hz and 1200 Hz.

Top module: `fsk_tape_mod`

## Requirements
- R1: While reset is asserted and just after it is released, `tone_out` is low. After reset the captured bit is one (idle mark) and the speed is low, so `tone_out` makes 16 transitions in any window of 16*TICK_DIV system cycles before the first strobe.
- R2: A one bit at low speed (`speed_hi`=0) gives exactly 16 transitions of `tone_out` over a bit period of 16*TICK_DIV cycles.
- R3: A zero bit at low speed gives exactly 8 transitions of `tone_out` over a bit period of 16*TICK_DIV cycles.
- R4: A one bit at high speed (`speed_hi`=1) gives exactly 2 transitions of `tone_out` over a bit period of 4*TICK_DIV cycles.
- R5: A zero bit at high speed gives exactly 1 transition of `tone_out` over a bit period of 4*TICK_DIV cycles.
- R6: `ser_data` and `speed_hi` are captured only in a cycle where `bit_strobe` is 1. Changes on them in any other cycle have no effect on `tone_out`. A tone tick in the strobe cycle still uses the previous bit.
- R7: `tone_out` changes only in tone-tick cycles. Base ticks come every TICK_DIV cycles. In low-speed mode every base tick is a tone tick; in high-speed mode every second one is.
- R8: While the captured bit is one, the first divider stage is held clear. A zero bit that follows a one therefore makes its first transition on its second tone tick. In low speed, that transition comes 2*TICK_DIV cycles after the last transition of the one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_data | input | 1 | Serial bit to encode (1 = mark) |
| speed_hi | input | 1 | Speed select: 0 low speed, 1 high speed |
| bit_strobe | input | 1 | One-cycle pulse at each bit boundary |
| tone_out | output | 1 | FSK square-wave tone |

## Verification
The hardest situation to reach is a tone tick that falls in the same cycle as the bit strobe. In that cycle the tick must still be charged to the old bit. The tick phase runs free from reset, and the strobes repeat at a multiple of the tick period. Before each burst of random bits, the stimulus therefore waits a random 0 to TICK_DIV-1 cycles, which moves the strobe across every tick phase. Within each bit, the data and speed inputs are also changed at random, so a capture outside the strobe cycle would change the transition count.

// File: rtl/fsk_pkg.sv
package fsk_pkg;

  typedef enum logic {
    SPEED_LOW  = 1'b0,
    SPEED_HIGH = 1'b1
  } speed_e;

  // Tone ticks per bit in each speed mode
  localparam int unsigned TICKS_PER_BIT_LOW  = 16;
  localparam int unsigned TICKS_PER_BIT_HIGH = 2;

endpackage

// File: rtl/fsk_rst_sync.sv
module fsk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/fsk_tick_gen.sv
module fsk_tick_gen
  import fsk_pkg::*;
#(
  parameter int unsigned TICK_DIV = 10417
) (
  input  logic   clk,
  input  logic   rst_n,
  input  speed_e speed,
  output logic   tone_tick
);

  localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic base_tick;
  logic half_q, half_d;

  generate
    if (TICK_DIV > 1) begin : g_div
      logic [CW-1:0] cnt_q, cnt_d;

      always_comb begin
        base_tick = (cnt_q == CW'(TICK_DIV - 1));
        cnt_d     = base_tick ? '0 : cnt_q + CW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      // base tick is a one-cycle pulse
      assert_base_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        base_tick |=> !base_tick);
    end else begin : g_nodiv
      assign base_tick = 1'b1;
    end
  endgenerate

  // half-rate phase: selects every second base tick at high speed
  always_comb begin
    half_d = half_q;
    if (base_tick) half_d = ~half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= half_d;
  end

  assign tone_tick = base_tick & ((speed == SPEED_LOW) | half_q);

  // high speed: two tone ticks never fall on consecutive base ticks
  assert_high_alternate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (speed == SPEED_HIGH) && tone_tick |=> !half_q);

endmodule

// File: rtl/fsk_bit_sync.sv
module fsk_bit_sync
  import fsk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   bit_strobe,
  input  logic   ser_data,
  input  logic   speed_hi,
  output logic   mark_q,
  output speed_e speed_q
);

  logic   mark_d;
  speed_e speed_d;

  always_comb begin
    mark_d  = mark_q;
    speed_d = speed_q;
    if (bit_strobe) begin
      mark_d  = ser_data;
      speed_d = speed_e'(speed_hi);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_q  <= 1'b1;
      speed_q <= SPEED_LOW;
    end else begin
      mark_q  <= mark_d;
      speed_q <= speed_d;
    end
  end

  assert_hold_between_strobes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_strobe |=> $stable(mark_q) && $stable(speed_q));

  assert_capture_on_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |=> (mark_q == $past(ser_data)));

endmodule

// File: rtl/fsk_tone_div.sv
module fsk_tone_div (
  input  logic clk,
  input  logic rst_n,
  input  logic tone_tick,
  input  logic mark,
  output logic tone_out
);

  logic pre_q, pre_d;
  logic out_q, out_d;

  always_comb begin
    pre_d = pre_q;
    out_d = out_q;
    // first stage: cleared while mark, otherwise toggles on each tone tick
    if (mark)           pre_d = 1'b0;
    else if (tone_tick) pre_d = ~pre_q;
    // output stage: toggles when enabled by mark or by the first stage
    if (tone_tick && (mark || pre_q)) out_d = ~out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      pre_q <= pre_d;
      out_q <= out_d;
    end
  end

  assign tone_out = out_q;

  assert_quiet_without_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tone_tick |=> $stable(tone_out));

  assert_mark_toggles_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mark && tone_tick |=> tone_out != $past(tone_out));

  assert_pre_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mark |=> !pre_q);

  assert_space_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mark && tone_tick && !pre_q |=> $stable(tone_out));

endmodule

// File: rtl/fsk_tape_mod.sv
module fsk_tape_mod
  import fsk_pkg::*;
#(
  parameter int unsigned TICK_DIV = 10417
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_data,
  input  logic speed_hi,
  input  logic bit_strobe,
  output logic tone_out
);

  logic   rst_n_int;
  logic   mark_q;
  speed_e speed_q;
  logic   tone_tick;

  fsk_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  fsk_bit_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .bit_strobe (bit_strobe),
    .ser_data   (ser_data),
    .speed_hi   (speed_hi),
    .mark_q     (mark_q),
    .speed_q    (speed_q)
  );

  fsk_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .speed     (speed_q),
    .tone_tick (tone_tick)
  );

  fsk_tone_div u_div (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .tone_tick (tone_tick),
    .mark      (mark_q),
    .tone_out  (tone_out)
  );

  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_n_int |=> !tone_out);

endmodule

// File: tb/test_fsk_tape_mod.sv
module test_fsk_tape_mod;

  localparam int D = 6;

  logic clk = 1'b0;
  logic rst_n, ser_data, speed_hi, bit_strobe;
  logic tone_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // monitor state
  int cyc = 0, ntog = 0, last_tog = 0, first_gap = 0;
  bit arm = 0;
  logic prev_out = 1'b0;

  // pending bit window
  bit    pend_valid = 0;
  int    pend_base = 0, pend_exp = 0;
  string pend_req = "";
  bit    pend_gap = 0;
  bit    last_d = 1, last_hi = 0;

  always #10 clk = ~clk;

  fsk_tape_mod #(.TICK_DIV(D)) i_fsk_tape_mod (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data),
    .speed_hi(speed_hi), .bit_strobe(bit_strobe), .tone_out(tone_out)
  );

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (tone_out !== prev_out) begin
      ntog = ntog + 1;
      if (arm) begin
        first_gap = cyc - last_tog;
        arm = 0;
      end
      last_tog = cyc;
    end
    prev_out = tone_out;
  end

  task automatic step();
    @(negedge clk);
    #5;
  endtask

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_tog(bit d, bit hi);
    if (hi) return d ? 2 : 1;
    return d ? 16 : 8;
  endfunction

  function automatic string req_of(bit d, bit hi);
    if (hi) return d ? "R4" : "R5";
    return d ? "R2" : "R3";
  endfunction

  task automatic close_pending();
    if (pend_valid) begin
      check({pend_req, "/R6"}, ntog - pend_base, pend_exp);
      if (pend_gap) check("R8", first_gap, 2 * D);
    end
    pend_valid = 0;
  endtask

  task automatic send_bit(bit d, bit hi, bit wiggle);
    int p;
    ser_data = d;
    speed_hi = hi;
    bit_strobe = 1'b1;
    step();
    bit_strobe = 1'b0;
    close_pending();
    p = hi ? 4 * D : 16 * D;
    pend_base = ntog;
    pend_exp = exp_tog(d, hi);
    pend_req = req_of(d, hi);
    pend_gap = last_d && !last_hi && !d && !hi;
    pend_valid = 1;
    arm = 1;
    last_d = d;
    last_hi = hi;
    for (int i = 1; i < p; i++) begin
      if (wiggle) begin
        if ($urandom_range(0, 2) == 0) ser_data = 1'($urandom_range(0, 1));
        if ($urandom_range(0, 2) == 0) speed_hi = 1'($urandom_range(0, 1));
      end
      step();
    end
  endtask

  task automatic flush();
    step();
    close_pending();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int b;
    void'($urandom(32'd424242));
    rst_n = 1'b0;
    ser_data = 1'b1;
    speed_hi = 1'b0;
    bit_strobe = 1'b0;
    repeat (4) step();
    check("R1 out in reset", int'(tone_out), 0);
    rst_n = 1'b1;
    step();
    check("R1 out after release", int'(tone_out), 0);
    repeat (3) step();
    b = ntog;
    repeat (16 * D) step();
    check("R1 idle mark low speed", ntog - b, 16);

    // directed low speed (includes one->zero for R8)
    send_bit(1, 0, 0); send_bit(1, 0, 0); send_bit(0, 0, 0);
    send_bit(0, 0, 0); send_bit(1, 0, 0); send_bit(0, 0, 0);
    flush();
    // directed high speed
    send_bit(1, 1, 0); send_bit(0, 1, 0); send_bit(0, 1, 0);
    send_bit(1, 1, 0); send_bit(1, 1, 0); send_bit(0, 1, 0);
    flush();
    // mode switches at boundaries, with wiggles between strobes (R6)
    send_bit(1, 0, 1); send_bit(0, 1, 1); send_bit(1, 1, 1);
    send_bit(0, 0, 1); send_bit(1, 0, 1); send_bit(0, 0, 1);
    flush();

    // random bursts, each shifted to a random tick phase
    for (int burst = 0; burst < 10; burst++) begin
      repeat ($urandom_range(0, D - 1)) step();
      for (int i = 0; i < 16; i++)
        send_bit(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1);
      flush();
    end

    done = 1;
    summary();
    $finish;
  end

endmodule